// File: doc/BRIEF.md
# External Memory Write Bus Sequencer

This block converts single-word write requests from the core into a timed write cycle on an external parallel bus. It drives a 23-bit address, 16-bit data, an active-low read/write line, an active-low write strobe, separate active-low memory and I/O strobes, and a 2-bit space select. In its shortest form a write has three bus cycles: a setup cycle, a strobe cycle and a hold cycle.

Three settings shape the sequence. A wait-state count lengthens only the strobe cycle. A bus-clock divide factor slows every bus cycle by the same amount. A dead bank-switch cycle is added on its own whenever the new address falls in a different 32K-word bank from the previous write. The core offers a request with `req`. The block takes it only while idle and returns a one-clock `ack` when the hold cycle ends. The bus-cycle counter is held at zero while the bus is idle. It runs only during an access, and a new request still starts its first bus cycle on the next core clock.

Top module: `ext_wr_seq`

## Requirements
- R1: After reset, `bus_rw_n`, `bus_we_n`, `bus_mstrb_n` and `bus_iostrb_n` are high and `ack` is low. The configuration resets to divide-by-1 and 14 wait states.
- R2: With zero wait states and no bank switch, an access takes exactly three bus cycles in this order: setup, strobe, hold. That is 3×D core cycles, where D is the divide factor.
- R3: Each wait state adds one bus cycle to the strobe phase only, so the write strobe is low for (1+W)×D core cycles. A programmed wait count above 14 is stored as 14.
- R4: `cfg_div` encoding: 2'b00 gives D=1, 2'b01 gives D=2, 2'b10 gives D=3 and 2'b11 gives D=4. Every bus cycle of the access, including the bank-switch cycle, lasts D core cycles.
- R5: One extra bus cycle is inserted before the setup cycle when address bits [22:15] differ from those of the previous accepted write. The first write after reset always gets this cycle. During this cycle `bus_rw_n` and all strobes stay high.
- R6: `req_space` encoding: 2'b00 is program, 2'b01 is data, 2'b10 is I/O, and 2'b11 is treated as memory. An I/O write pulses only `bus_iostrb_n`; any other write pulses only `bus_mstrb_n`.
- R7: The write strobe and the selected space strobe are low only during the strobe phase, including its wait states. `bus_rw_n` is low from the setup cycle through the hold cycle.
- R8: `bus_addr`, `bus_data` and `bus_space` hold the values captured at acceptance, unchanged from the setup cycle through the hold cycle.
- R9: `ack` is high for exactly one core cycle, the last core cycle of the hold phase. A request is accepted only while the sequencer is idle.
- R10: A configuration write made during an access does not change that access. It applies from the next accepted request.
- R11: The bus-cycle counter is held while idle. The first bus cycle of an accepted request begins on the core clock right after acceptance, so an access from `req` to `ack` takes exactly D×(3+W+B) core cycles, where B is 1 with a bank switch and 0 without.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_div | input | 2 | Bus-clock divide factor to store |
| cfg_wait | input | 4 | Wait-state count to store (saturates at 14) |
| req | input | 1 | Write request from the core |
| req_addr | input | 23 | Write address |
| req_data | input | 16 | Write data |
| req_space | input | 2 | Target space of the write |
| ack | output | 1 | One-cycle completion pulse |
| bus_addr | output | 23 | External address bus |
| bus_data | output | 16 | External data bus |
| bus_rw_n | output | 1 | Read/write line, low while a write is in progress |
| bus_we_n | output | 1 | Active-low write strobe |
| bus_mstrb_n | output | 1 | Active-low memory strobe |
| bus_iostrb_n | output | 1 | Active-low I/O strobe |
| bus_space | output | 2 | Space select for the current access |

## Verification
Some properties are checked by assertions on every cycle:
- the two space strobes are never low together;
- the write strobe is low only when a space strobe is low, and only inside an active write;
- address, data and space do not move while `bus_rw_n` is low;
- `ack` never lasts more than one cycle and falls inside the hold phase.

Other behaviour can only be shown by the bench's transactions, which measure the cycle counts against a reference model:
- the exact phase lengths for each divide factor and wait count;
- whether a bank-switch cycle appears for a given address history;
- wait-count saturation;
- that a configuration change made during an access is deferred.

// File: rtl/ewbs_pkg.sv
package ewbs_pkg;

    localparam int ADDR_W   = 23;
    localparam int DATA_W   = 16;
    localparam int BANK_LSB = 15;
    localparam int WAIT_W   = 4;
    localparam int WAIT_MAX = 14;
    localparam int DIV_W    = 2;
    localparam int SPACE_W  = 2;

    localparam logic [WAIT_W-1:0] WAIT_LIMIT = WAIT_W'(WAIT_MAX);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BANK,
        ST_LEAD,
        ST_STROBE,
        ST_TRAIL
    } seq_state_e;

    typedef enum logic [SPACE_W-1:0] {
        SP_PROG = 2'b00,
        SP_DATA = 2'b01,
        SP_IO   = 2'b10,
        SP_RSVD = 2'b11
    } space_e;

    typedef struct packed {
        logic [ADDR_W-1:0]  addr;
        logic [DATA_W-1:0]  data;
        logic [SPACE_W-1:0] space;
    } wr_req_t;

    typedef struct packed {
        logic [DIV_W-1:0]  div;
        logic [WAIT_W-1:0] waits;
    } bus_cfg_t;

    function automatic logic [WAIT_W-1:0] clamp_waits(input logic [WAIT_W-1:0] w);
        return (w > WAIT_LIMIT) ? WAIT_LIMIT : w;
    endfunction

    function automatic logic targets_io(input logic [SPACE_W-1:0] s);
        return s == SP_IO;
    endfunction

endpackage

// File: rtl/ewbs_cfg.sv
module ewbs_cfg
    import ewbs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [DIV_W-1:0]  div_in,
    input  logic [WAIT_W-1:0] wait_in,
    output bus_cfg_t          cfg
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg.div   <= '0;
            cfg.waits <= WAIT_LIMIT;
        end else if (we) begin
            cfg.div   <= div_in;
            cfg.waits <= clamp_waits(wait_in);
        end
    end

endmodule

// File: rtl/ewbs_phase_div.sv
module ewbs_phase_div #(
    parameter int DIV_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div_sel,
    output logic             tick
);

    logic [DIV_W-1:0] cnt;

    assign tick = run && (cnt == div_sel);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/ewbs_bank_track.sv
module ewbs_bank_track #(
    parameter int ADDR_W   = 23,
    parameter int BANK_LSB = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic [ADDR_W-1:0] addr_in,
    output logic              need_switch
);

    localparam int BANK_W = ADDR_W - BANK_LSB;

    logic              valid;
    logic [BANK_W-1:0] last_bank;
    logic [BANK_W-1:0] new_bank;

    assign new_bank    = addr_in[ADDR_W-1:BANK_LSB];
    assign need_switch = !valid || (new_bank != last_bank);

    always_ff @(posedge clk) begin
        if (rst) begin
            valid     <= 1'b0;
            last_bank <= '0;
        end else if (capture) begin
            valid     <= 1'b1;
            last_bank <= new_bank;
        end
    end

endmodule

// File: rtl/ewbs_seq.sv
module ewbs_seq
    import ewbs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             req,
    input  wr_req_t          req_in,
    input  bus_cfg_t         cfg,
    input  logic             need_switch,
    input  logic             tick,
    output logic             accept,
    output seq_state_e       state,
    output wr_req_t          cur,
    output logic [DIV_W-1:0] act_div,
    output logic             done
);

    logic [WAIT_W-1:0] act_waits;
    logic [WAIT_W-1:0] wait_cnt;

    assign accept = (state == ST_IDLE) && req;
    assign done   = (state == ST_TRAIL) && tick;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            cur       <= '0;
            act_div   <= '0;
            act_waits <= '0;
            wait_cnt  <= '0;
        end else if (accept) begin
            cur       <= req_in;
            act_div   <= cfg.div;
            act_waits <= cfg.waits;
            wait_cnt  <= '0;
            state     <= need_switch ? ST_BANK : ST_LEAD;
        end else if (tick) begin
            unique case (state)
                ST_BANK:   state <= ST_LEAD;
                ST_LEAD:   state <= ST_STROBE;
                ST_STROBE: begin
                    if (wait_cnt == act_waits) begin
                        state <= ST_TRAIL;
                    end else begin
                        wait_cnt <= wait_cnt + 1'b1;
                    end
                end
                ST_TRAIL:  state <= ST_IDLE;
                default:   state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/ext_wr_seq.sv
module ext_wr_seq
    import ewbs_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_we,
    input  logic [DIV_W-1:0]   cfg_div,
    input  logic [WAIT_W-1:0]  cfg_wait,
    input  logic               req,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [DATA_W-1:0]  req_data,
    input  logic [SPACE_W-1:0] req_space,
    output logic               ack,
    output logic [ADDR_W-1:0]  bus_addr,
    output logic [DATA_W-1:0]  bus_data,
    output logic               bus_rw_n,
    output logic               bus_we_n,
    output logic               bus_mstrb_n,
    output logic               bus_iostrb_n,
    output logic [SPACE_W-1:0] bus_space
);

    bus_cfg_t         cfg;
    wr_req_t          req_in;
    wr_req_t          cur;
    seq_state_e       state;
    logic             accept;
    logic             need_switch;
    logic             tick;
    logic             running;
    logic [DIV_W-1:0] act_div;

    assign req_in.addr  = req_addr;
    assign req_in.data  = req_data;
    assign req_in.space = req_space;
    assign running      = (state != ST_IDLE);

    ewbs_cfg u_cfg (
        .clk     (clk),
        .rst     (rst),
        .we      (cfg_we),
        .div_in  (cfg_div),
        .wait_in (cfg_wait),
        .cfg     (cfg)
    );

    ewbs_bank_track #(
        .ADDR_W   (ADDR_W),
        .BANK_LSB (BANK_LSB)
    ) u_bank (
        .clk         (clk),
        .rst         (rst),
        .capture     (accept),
        .addr_in     (req_addr),
        .need_switch (need_switch)
    );

    ewbs_phase_div #(
        .DIV_W (DIV_W)
    ) u_div (
        .clk     (clk),
        .rst     (rst),
        .run     (running),
        .div_sel (act_div),
        .tick    (tick)
    );

    ewbs_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .req         (req),
        .req_in      (req_in),
        .cfg         (cfg),
        .need_switch (need_switch),
        .tick        (tick),
        .accept      (accept),
        .state       (state),
        .cur         (cur),
        .act_div     (act_div),
        .done        (ack)
    );

    logic in_write;
    logic strobing;

    assign in_write = (state == ST_LEAD) || (state == ST_STROBE) || (state == ST_TRAIL);
    assign strobing = (state == ST_STROBE);

    assign bus_addr     = cur.addr;
    assign bus_data     = cur.data;
    assign bus_space    = cur.space;
    assign bus_rw_n     = !in_write;
    assign bus_we_n     = !strobing;
    assign bus_mstrb_n  = !(strobing && !targets_io(cur.space));
    assign bus_iostrb_n = !(strobing && targets_io(cur.space));

endmodule

// File: rtl/ext_wr_seq_chk.sv
module ext_wr_seq_chk (
    input logic        clk,
    input logic        rst,
    input logic        ack,
    input logic [22:0] bus_addr,
    input logic [15:0] bus_data,
    input logic        bus_rw_n,
    input logic        bus_we_n,
    input logic        bus_mstrb_n,
    input logic        bus_iostrb_n,
    input logic [1:0]  bus_space
);

    AST_SINGLE_SPACE_STROBE: assert property (@(posedge clk) disable iff (rst)
        !(!bus_mstrb_n && !bus_iostrb_n)); // R6

    AST_WE_NEEDS_SPACE_STROBE: assert property (@(posedge clk) disable iff (rst)
        !bus_we_n |-> (!bus_mstrb_n || !bus_iostrb_n)); // R7

    AST_STROBE_INSIDE_WRITE: assert property (@(posedge clk) disable iff (rst)
        (!bus_mstrb_n || !bus_iostrb_n) |-> (!bus_rw_n && !bus_we_n)); // R7

    AST_BUS_HELD: assert property (@(posedge clk) disable iff (rst)
        (!bus_rw_n && $past(!bus_rw_n)) |->
            ($stable(bus_addr) && $stable(bus_data) && $stable(bus_space))); // R8

    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (rst)
        ack |=> !ack); // R9

    AST_ACK_IN_HOLD: assert property (@(posedge clk) disable iff (rst)
        ack |-> (!bus_rw_n && bus_we_n)); // R9

endmodule

bind ext_wr_seq ext_wr_seq_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .ack          (ack),
    .bus_addr     (bus_addr),
    .bus_data     (bus_data),
    .bus_rw_n     (bus_rw_n),
    .bus_we_n     (bus_we_n),
    .bus_mstrb_n  (bus_mstrb_n),
    .bus_iostrb_n (bus_iostrb_n),
    .bus_space    (bus_space)
);

// File: tb/ext_wr_seq_tb.sv
module ext_wr_seq_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_div = 2'b00;
    logic [3:0]  cfg_wait = 4'd0;
    logic        req = 1'b0;
    logic [22:0] req_addr = '0;
    logic [15:0] req_data = '0;
    logic [1:0]  req_space = 2'b00;
    logic        ack;
    logic [22:0] bus_addr;
    logic [15:0] bus_data;
    logic        bus_rw_n, bus_we_n, bus_mstrb_n, bus_iostrb_n;
    logic [1:0]  bus_space;

    int checks = 0;
    int errors = 0;
    bit done_flag = 0;

    int  m_div = 1;
    int  m_wait = 14;
    bit  m_valid = 0;
    int  m_bank = 0;

    always #10 clk = ~clk;

    ext_wr_seq u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_div(cfg_div), .cfg_wait(cfg_wait),
        .req(req), .req_addr(req_addr), .req_data(req_data), .req_space(req_space),
        .ack(ack), .bus_addr(bus_addr), .bus_data(bus_data), .bus_rw_n(bus_rw_n),
        .bus_we_n(bus_we_n), .bus_mstrb_n(bus_mstrb_n), .bus_iostrb_n(bus_iostrb_n),
        .bus_space(bus_space)
    );

    function automatic int div_of(input logic [1:0] code);
        return int'(code) + 1;
    endfunction

    function automatic int sat_of(input logic [3:0] w);
        return (int'(w) > 14) ? 14 : int'(w);
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [1:0] d, input logic [3:0] w);
        cfg_we = 1'b1; cfg_div = d; cfg_wait = w;
        @(negedge clk);
        cfg_we = 1'b0;
        m_div = div_of(d);
        m_wait = sat_of(w);
    endtask

    task automatic run_txn(input logic [22:0] a, input logic [15:0] dat,
                           input logic [1:0] sp, input bit mid_cfg,
                           input logic [1:0] nd, input logic [3:0] nw);
        int dv = m_div;
        int wt = m_wait;
        int bk = (!m_valid || m_bank != int'(a[22:15])) ? 1 : 0;
        int n = 0, rw_cnt = 0, we_cnt = 0, ms_cnt = 0, io_cnt = 0, bad = 0;
        bit want_io = (sp == 2'b10);
        m_valid = 1;
        m_bank = int'(a[22:15]);
        req = 1'b1; req_addr = a; req_data = dat; req_space = sp;
        forever begin
            @(negedge clk);
            n++;
            if (!bus_rw_n) rw_cnt++;
            if (!bus_we_n) begin
                we_cnt++;
                if (bus_addr != a || bus_data != dat || bus_space != sp) bad++;
            end
            if (!bus_mstrb_n) ms_cnt++;
            if (!bus_iostrb_n) io_cnt++;
            if (mid_cfg && n == 2) begin
                cfg_we = 1'b1; cfg_div = nd; cfg_wait = nw;
            end
            if (mid_cfg && n == 3) cfg_we = 1'b0;
            if (ack || n > 500) break;
        end
        req = 1'b0;
        cfg_we = 1'b0;
        chk(n == dv * (3 + wt + bk), "R2 R4 R11 R10 total cycles", n, dv * (3 + wt + bk));
        chk(we_cnt == dv * (1 + wt), "R3 strobe-phase cycles", we_cnt, dv * (1 + wt));
        chk(rw_cnt == dv * (3 + wt), "R7 rw low cycles", rw_cnt, dv * (3 + wt));
        chk(n - rw_cnt == dv * bk, "R5 bank-switch cycles", n - rw_cnt, dv * bk);
        chk((want_io ? io_cnt : ms_cnt) == we_cnt && (want_io ? ms_cnt : io_cnt) == 0,
            "R6 space strobe", want_io ? io_cnt : ms_cnt, we_cnt);
        chk(bad == 0, "R8 bus held values", bad, 0);
        @(negedge clk);
        chk(ack == 1'b0 && bus_rw_n == 1'b1, "R9 ack single pulse", int'(ack), 0);
        if (mid_cfg) begin
            m_div = div_of(nd);
            m_wait = sat_of(nw);
        end
    endtask

    initial begin
        #(20 * 200000);
        if (!done_flag) begin
            errors++;
            $display("FAIL watchdog R9 actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(bus_rw_n && bus_we_n && bus_mstrb_n && bus_iostrb_n && !ack,
            "R1 reset outputs", int'({bus_rw_n, bus_we_n, bus_mstrb_n, bus_iostrb_n, ack}), 5'b11110);
        // R1: default config gives D=1, W=14; first write also gets a bank cycle (R5)
        run_txn(23'h000100, 16'hA5A5, 2'b01, 0, 2'b00, 4'd0);
        write_cfg(2'b00, 4'd0);
        run_txn(23'h000200, 16'h1234, 2'b10, 0, 2'b00, 4'd0);   // R2 minimal, I/O
        run_txn(23'h008000, 16'h0F0F, 2'b00, 0, 2'b00, 4'd0);   // R5 bank crossing
        run_txn(23'h00FFFF, 16'hFFFF, 2'b11, 0, 2'b00, 4'd0);   // R6 reserved -> memory
        write_cfg(2'b00, 4'd15);                                 // R3 saturation
        run_txn(23'h00C000, 16'h5555, 2'b01, 0, 2'b00, 4'd0);
        for (int d = 1; d < 4; d++) begin                        // R4 each divide code
            write_cfg(2'(d), 4'd2);
            run_txn(23'h00C010 + 23'(d), 16'(d), 2'b10, 0, 2'b00, 4'd0);
        end
        write_cfg(2'b01, 4'd1);
        run_txn(23'h7F8000, 16'hBEEF, 2'b01, 1, 2'b11, 4'd5);    // R10 deferred config
        run_txn(23'h7F8001, 16'hCAFE, 2'b00, 0, 2'b00, 4'd0);    // R10 new config in use
        for (int i = 0; i < 60; i++) begin
            logic [22:0] a = 23'($urandom);
            if ($urandom_range(1, 0) == 1) a[22:15] = 8'(m_bank);
            if ($urandom_range(3, 0) == 0)
                write_cfg(2'($urandom_range(3, 0)), 4'($urandom_range(15, 0)));
            run_txn(a, 16'($urandom), 2'($urandom_range(3, 0)),
                    $urandom_range(5, 0) == 0, 2'($urandom_range(3, 0)),
                    4'($urandom_range(15, 0)));
        end
        done_flag = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule